// File: doc/BRIEF.md
# Maskable Burst Address Counter

This block generates the word address for one port of a burst-capable memory. A programmable mask selects which low-order address bits take part in counting. The bits above the mask stay fixed, so a burst walks around inside an aligned region whose size is a power of two. Every step of the counter moves by one full memory word, not by one transfer beat on the external bus.

Loading an address starts a burst and also stores that address as the burst origin. A retransmit request returns the counter to the origin, so the same region can be read or written again. When the counting field is already all ones and another step is requested, a wrap-select input chooses the reload value. Low clears the counting field. High restores the origin.

An active-low early-warning output falls one step before the counting field reaches all ones, which gives the surrounding logic one cycle to prepare for the wrap. A dedicated clear input sets the counter to zero. When several controls act in the same cycle, they are served in this order: clear, load, retransmit, step, hold. All outputs are registered.

Top module: `burst_addr_ctr`

## Requirements
- R1: During and after a synchronous reset (`rst` high), `addr_o` is 0, `warn_n_o` is 1, the stored mask is all ones and the stored origin is 0.
- R2: When `clr_i` is high, `addr_o` is 0 after the next clock edge, whatever the other controls do. The stored origin and the stored mask are kept.
- R3: When `load_i` is high and `clr_i` is low, `addr_o` takes `addr_i` after the next edge. In the same edge `addr_i` is stored as the origin and `mask_i` is stored as the mask. The mask must be a contiguous run of ones starting at bit 0.
- R4: When `retx_n_i` is low and neither `clr_i` nor `load_i` is high, `addr_o` takes the stored origin after the next edge.
- R5: When `inc_i` is high, no higher-priority control is active, and the counting field (the bits of `addr_o` where the mask is 1) is not all ones, the field increases by one after the next edge. The bits where the mask is 0 do not change.
- R6: A step from an all-ones counting field with `wrap_mirror_i` low clears the field to zero. The bits where the mask is 0 are kept.
- R7: A step from an all-ones counting field with `wrap_mirror_i` high sets `addr_o` to the stored origin.
- R8: `warn_n_o` is 0 exactly when bit 0 of the stored mask is 1 and the counting field of `addr_o` equals the mask with bit 0 cleared. At that point the next step makes the field all ones. The flag changes in the same cycle as `addr_o`.
- R9: With `clr_i`, `load_i` and `inc_i` low and `retx_n_i` high, `addr_o` and `warn_n_o` hold their values.
- R10: Load takes priority over retransmit and step. Retransmit takes priority over step.
- R11: With a mask of all zeros the counting field is empty, so every step counts as a rollover. With `wrap_mirror_i` low the address holds. With it high the address takes the stored origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Counter clear, highest priority |
| load_i | input | 1 | Load `addr_i` as address and origin, load `mask_i` as mask |
| retx_n_i | input | 1 | Retransmit request, active low: return to the origin |
| inc_i | input | 1 | Advance the counter by one word |
| wrap_mirror_i | input | 1 | Rollover reload select: 0 = clear field, 1 = origin |
| addr_i | input | AW | Address to load |
| mask_i | input | AW | Counting mask to load (contiguous ones from bit 0) |
| addr_o | output | AW | Current word address |
| warn_n_o | output | 1 | Early warning, active low, one step before the field is all ones |

## Verification
The bench builds the counter with `AW` set to 8 instead of the default 18. With that width, random loads, steps and retransmits reach both kinds of rollover many times within a short run. Mask sizes are drawn from every value between zero bits and the full width, with a bias toward 0 to 3 bits. This brings the empty field, the one-bit field (where the warning sits on field value 0) and frequent wraps within reach, alongside long runs under wide masks.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_RETX  = 3'd3,
    OP_STEP  = 3'd4
  } bac_op_e;
endpackage

// File: rtl/bac_arbiter.sv
module bac_arbiter
  import bac_pkg::*;
(
  input  logic    clr_i,
  input  logic    load_i,
  input  logic    retx_n_i,
  input  logic    inc_i,
  output bac_op_e op_o
);
  // Fixed priority: clear, load, retransmit, step, hold (R10)
  always_comb begin
    if (clr_i)          op_o = OP_CLEAR;
    else if (load_i)    op_o = OP_LOAD;
    else if (!retx_n_i) op_o = OP_RETX;
    else if (inc_i)     op_o = OP_STEP;
    else                op_o = OP_HOLD;
  end

  always_comb begin
    a_r10_one_op : assert (!(clr_i && op_o != OP_CLEAR));
  end
endmodule

// File: rtl/bac_step.sv
module bac_step #(
  parameter int AW = 18
) (
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] mask_i,
  input  logic [AW-1:0] origin_i,
  input  logic          wrap_origin_i,
  output logic [AW-1:0] next_o,
  output logic          at_top_o
);
  logic [AW-1:0] fixed_part;
  logic [AW-1:0] bumped;

  assign fixed_part = cur_i & ~mask_i;
  assign bumped     = cur_i + {{(AW-1){1'b0}}, 1'b1};
  assign at_top_o   = ((cur_i & mask_i) == mask_i);

  // The mask is contiguous from bit 0, so a carry never leaves the field
  // unless the field is already all ones, which takes the rollover path.
  always_comb begin
    if (at_top_o) next_o = wrap_origin_i ? origin_i : fixed_part;
    else          next_o = fixed_part | (bumped & mask_i);
  end
endmodule

// File: rtl/bac_warn.sv
module bac_warn #(
  parameter int AW = 18
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] mask_i,
  output logic          warn_n_o
);
  logic [AW-1:0] pre_top;

  assign pre_top  = mask_i & ~{{(AW-1){1'b0}}, 1'b1};
  assign warn_n_o = !(mask_i[0] && ((addr_i & mask_i) == pre_top));
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import bac_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic          retx_n_i,
  input  logic          inc_i,
  input  logic          wrap_mirror_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] mask_i,
  output logic [AW-1:0] addr_o,
  output logic          warn_n_o
);
  localparam logic [AW-1:0] ONES  = {AW{1'b1}};
  localparam logic [AW-1:0] ZEROS = {AW{1'b0}};

  bac_op_e       op;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] origin_q, origin_d;
  logic [AW-1:0] mask_q, mask_d;
  logic [AW-1:0] step_val;
  logic          at_top;
  logic          warn_q, warn_d;

  bac_arbiter u_arb (
    .clr_i    (clr_i),
    .load_i   (load_i),
    .retx_n_i (retx_n_i),
    .inc_i    (inc_i),
    .op_o     (op)
  );

  bac_step #(.AW(AW)) u_step (
    .cur_i         (addr_q),
    .mask_i        (mask_q),
    .origin_i      (origin_q),
    .wrap_origin_i (wrap_mirror_i),
    .next_o        (step_val),
    .at_top_o      (at_top)
  );

  always_comb begin
    addr_d   = addr_q;
    origin_d = origin_q;
    mask_d   = mask_q;
    case (op)
      OP_CLEAR: addr_d = ZEROS;
      OP_LOAD: begin
        addr_d   = addr_i;
        origin_d = addr_i;
        mask_d   = mask_i;
      end
      OP_RETX:  addr_d = origin_q;
      OP_STEP:  addr_d = step_val;
      default:  addr_d = addr_q;
    endcase
  end

  // Warning computed from the next state so it lands with addr_o (R8)
  bac_warn #(.AW(AW)) u_warn (
    .addr_i   (addr_d),
    .mask_i   (mask_d),
    .warn_n_o (warn_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= ZEROS;
      origin_q <= ZEROS;
      mask_q   <= ONES;
      warn_q   <= 1'b1;
    end else begin
      addr_q   <= addr_d;
      origin_q <= origin_d;
      mask_q   <= mask_d;
      warn_q   <= warn_d;
    end
  end

  assign addr_o   = addr_q;
  assign warn_n_o = warn_q;

  // ---------------------------------------------------------------- checks
  a_r1_reset_state : assert property (@(posedge clk)
    rst |=> (addr_o == ZEROS && warn_n_o && mask_q == ONES && origin_q == ZEROS));

  a_r2_clear_wins : assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (addr_o == ZEROS && $stable(origin_q)));

  a_r3_load_takes : assert property (@(posedge clk) disable iff (rst)
    (!clr_i && load_i) |=> (addr_o == $past(addr_i) && origin_q == $past(addr_i)));

  a_r3_mask_contiguous : assert property (@(posedge clk) disable iff (rst)
    load_i |-> ((mask_i & (mask_i + {{(AW-1){1'b0}}, 1'b1})) == ZEROS));

  a_r4_retx_origin : assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && !retx_n_i) |=> (addr_o == $past(origin_q)));

  a_r5_high_bits_fixed : assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && retx_n_i && inc_i && (addr_o & mask_q) != mask_q)
    |=> ((addr_o & ~mask_q) == ($past(addr_o) & ~mask_q)));

  a_r7_wrap_origin : assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && retx_n_i && inc_i && wrap_mirror_i && (addr_o & mask_q) == mask_q)
    |=> (addr_o == $past(origin_q)));

  a_r8_warn_precedes_top : assert property (@(posedge clk) disable iff (rst)
    (!warn_n_o && !clr_i && !load_i && retx_n_i && inc_i)
    |=> ((addr_o & mask_q) == mask_q));

  a_r9_hold : assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && retx_n_i && !inc_i) |=> ($stable(addr_o) && $stable(warn_n_o)));
endmodule

// File: tb/test_burst_addr_ctr.sv
`timescale 1ns/1ps
module test_burst_addr_ctr;
  localparam int AW = 8;
  localparam logic [AW-1:0] ONES = {AW{1'b1}};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr_i = 1'b0, load_i = 1'b0, retx_n_i = 1'b1, inc_i = 1'b0, wrap_mirror_i = 1'b0;
  logic [AW-1:0] addr_i = '0, mask_i = '0;
  logic [AW-1:0] addr_o;
  logic          warn_n_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  logic [AW-1:0] m_addr = '0, m_origin = '0, m_mask = ONES;

  always #2.5 clk = ~clk;

  burst_addr_ctr #(.AW(AW)) i_burst_addr_ctr (
    .clk(clk), .rst(rst), .clr_i(clr_i), .load_i(load_i), .retx_n_i(retx_n_i),
    .inc_i(inc_i), .wrap_mirror_i(wrap_mirror_i), .addr_i(addr_i), .mask_i(mask_i),
    .addr_o(addr_o), .warn_n_o(warn_n_o)
  );

  function automatic logic exp_warn(input logic [AW-1:0] a, input logic [AW-1:0] m);
    return !(m[0] && ((a & m) == (m & ~{{(AW-1){1'b0}}, 1'b1})));
  endfunction

  function automatic logic [AW-1:0] mask_of(input int k);
    logic [AW:0] w;
    w = ({{AW{1'b0}}, 1'b1} << k) - 1;
    return w[AW-1:0];
  endfunction

  task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Updates the model for one edge and returns the requirement exercised.
  function automatic string model_edge();
    string tag;
    if (clr_i) begin
      m_addr = '0; tag = "R2";
    end else if (load_i) begin
      m_addr = addr_i; m_origin = addr_i; m_mask = mask_i;
      tag = (!retx_n_i || inc_i) ? "R10" : "R3";
    end else if (!retx_n_i) begin
      m_addr = m_origin; tag = inc_i ? "R10" : "R4";
    end else if (inc_i) begin
      if ((m_addr & m_mask) == m_mask) begin
        tag = (m_mask == '0) ? "R11" : (wrap_mirror_i ? "R7" : "R6");
        m_addr = wrap_mirror_i ? m_origin : (m_addr & ~m_mask);
      end else begin
        m_addr = (m_addr & ~m_mask) | ((m_addr + 1'b1) & m_mask); tag = "R5";
      end
    end else tag = "R9";
    return tag;
  endfunction

  task automatic cycle(input logic c, input logic l, input logic rn, input logic i,
                       input logic w, input logic [AW-1:0] a, input logic [AW-1:0] m);
    string tag;
    clr_i = c; load_i = l; retx_n_i = rn; inc_i = i; wrap_mirror_i = w; addr_i = a; mask_i = m;
    @(posedge clk);
    tag = model_edge();
    @(negedge clk);
    check(tag, addr_o, m_addr);
    check("R8", {{(AW-1){1'b0}}, warn_n_o}, {{(AW-1){1'b0}}, exp_warn(m_addr, m_mask)});
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    check("R1", addr_o, '0);
    check("R1", {{(AW-1){1'b0}}, warn_n_o}, {{(AW-1){1'b0}}, 1'b1});
    rst = 1'b0;
    // R1: origin is zero after reset
    cycle(0, 0, 0, 0, 0, 8'h00, 8'h00);
    // R1: stored mask is all ones: field value fe raises the warning
    cycle(0, 1, 1, 0, 0, 8'hfd, ONES);
    cycle(0, 0, 1, 1, 0, 8'h00, 8'h00);           // fe, warn low (R8)
    cycle(0, 0, 1, 1, 0, 8'h00, 8'h00);           // ff
    cycle(0, 0, 1, 1, 0, 8'h00, 8'h00);           // R6 -> 00
    // R3/R5/R6: 4-bit field
    cycle(0, 1, 1, 0, 0, 8'ha5, 8'h0f);
    for (int k = 0; k < 11; k++) cycle(0, 0, 1, 1, 0, 8'h00, 8'h00);
    cycle(0, 0, 1, 0, 0, 8'h00, 8'h00);           // R9 hold
    // R7: 2-bit field wraps to origin
    cycle(0, 1, 1, 0, 0, 8'h3c, 8'h03);
    for (int k = 0; k < 4; k++) cycle(0, 0, 1, 1, 1, 8'h00, 8'h00);
    // R4 retransmit after steps
    cycle(0, 0, 1, 1, 0, 8'h00, 8'h00);
    cycle(0, 0, 0, 0, 0, 8'h00, 8'h00);
    // R10 priorities, R2 clear over load
    cycle(0, 1, 0, 1, 0, 8'h77, 8'h07);
    cycle(0, 0, 1, 1, 0, 8'h00, 8'h00);
    cycle(0, 0, 0, 1, 0, 8'h00, 8'h00);
    cycle(1, 1, 0, 1, 1, 8'h11, 8'h01);
    cycle(0, 0, 0, 0, 0, 8'h00, 8'h00);           // origin kept after clear
    // R11: empty field
    cycle(0, 1, 1, 0, 0, 8'h5a, 8'h00);
    cycle(0, 0, 1, 1, 0, 8'h00, 8'h00);
    cycle(1, 0, 1, 0, 0, 8'h00, 8'h00);
    cycle(0, 0, 1, 1, 1, 8'h00, 8'h00);
    // Constrained random
    for (int n = 0; n < 3000; n++) begin
      int k;
      k = ($urandom % 2 == 0) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, AW));
      cycle(($urandom % 40) == 0, ($urandom % 10) == 0, ($urandom % 16) != 0,
            ($urandom % 4) != 0, $urandom % 2, AW'($urandom), mask_of(k));
    end
    finish_run();
  end
endmodule